// File: doc/BRIEF.md
# GPIO Port Register Block with Masked-Write Aliases

This block holds the software-visible state of a group of general-purpose pins. The pins are arranged in banks. Each bank has up to four ports of eight pins. Every port has three writable registers: a configuration enable that hands the pin to this block, an output enable, and an output data value. It also has one read-only input register that returns the pad levels after they have passed through a two-flop synchronizer. A pad is driven only when its configuration bit and its output-enable bit are both 1.

Each writable register can also be reached at a second, masked address. A write there changes only the pins whose mask bit is set, so each pin can be updated with a single store and no read-modify-write sequence. The bus is a plain 32-bit register port. Writes take effect on the clock edge where the write strobe is high. Read data is a combinational function of the address.

Top module: `gpio_mask_port`

## Requirements
- R1: After reset, every configuration, output-enable and output-data bit is 0. All pads are therefore undriven with output value 0, and every register reads as 0.
- R2: A plain write replaces the whole register from write-data bits 7:0 and ignores bits 31:8. The plain registers sit at offset 0x00 (configuration), 0x10 (output enable) and 0x20 (output data).
- R3: A write to a masked alias updates pin n to write-data bit n only where write-data bit 8+n is 1, and every other pin keeps its value. The aliases are at 0x80 (configuration), 0x90 (output enable) and 0xA0 (output data).
- R4: A read returns the register in bits 7:0 and zeros in bits 31:8. A read of a masked alias returns the same value as its plain register.
- R5: The input register at offset 0x30 shows a pad level that changed before clock edge k after edge k+1, and not after edge k alone.
- R6: For each pin, the pad output enable is the AND of its configuration bit and its output-enable bit, and the pad output value equals its output-data bit. The pads change only on edges that carry a write.
- R7: Offsets that map to no register (0x40–0x7F, 0xB0–0xFF, a port index at or above the port count, a bank at or above the bank count) read as 0, and writes to them change nothing.
- R8: Writes to the input register address change neither the value read back from it nor any other register.
- R9: The register for pin g sits at bank×0x100 + port×4 + offset, with bank = g / 32, port = (g / 8) mod 4 and bit = g mod 8. Address bits 1:0 are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Byte address of the register access |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | NPIN | Asynchronous pad levels |
| pad_out | output | NPIN | Output value driven toward the pads |
| pad_oe | output | NPIN | Per-pin pad drive enable |

## Verification
The bench builds the block with two banks of four ports and eight pins each, giving 64 pins and a 9-bit address. The second bank exercises the bank field of the address and shows that a write to bank 1 leaves bank 0 untouched. Four ports per bank reach every port index. Eight pins per port put the mask field exactly in write-data bits 15:8, so a single store can combine a partial mask, an empty mask and a full mask.

// File: rtl/gpio_mask_pkg.sv
package gpio_mask_pkg;

  typedef enum logic [2:0] {
    K_CNF  = 3'd0,
    K_OE   = 3'd1,
    K_OUT  = 3'd2,
    K_IN   = 3'd3,
    K_NONE = 3'd4
  } reg_kind_e;

  // Register kind selected by address bits 7:4.
  function automatic reg_kind_e kind_of(input logic [3:0] nib);
    case (nib)
      4'h0, 4'h8: kind_of = K_CNF;
      4'h1, 4'h9: kind_of = K_OE;
      4'h2, 4'hA: kind_of = K_OUT;
      4'h3:       kind_of = K_IN;
      default:    kind_of = K_NONE;
    endcase
  endfunction

  function automatic logic is_alias(input logic [3:0] nib);
    is_alias = nib[3];
  endfunction

  // Keep unmasked bits, take masked bits from the new value.
  function automatic logic [15:0] merge_masked(input logic [15:0] old_v,
                                               input logic [15:0] mask_v,
                                               input logic [15:0] new_v);
    merge_masked = (old_v & ~mask_v) | (new_v & mask_v);
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [1:0]       since_rst;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q    <= '0;
      q         <= '0;
      since_rst <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
      if (since_rst != 2'd2) since_rst <= since_rst + 2'd1;
    end
  end

  // R5: synchronized value lags the pad by exactly two edges
  assert_two_stage_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (since_rst == 2'd2) |-> (q == $past(d, 2)));

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs #(
  parameter int PINS = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      wr_sel,     // one bit per writable register
  input  logic            wr_masked,
  input  logic [31:0]     wdata,
  output logic [PINS-1:0] cfg_q,
  output logic [PINS-1:0] oe_q,
  output logic [PINS-1:0] out_q
);
  import gpio_mask_pkg::*;

  localparam int NREG = 3;

  logic [PINS-1:0] regs_q [NREG];
  logic [PINS-1:0] wr_mask;
  logic [PINS-1:0] wr_val;

  assign wr_val  = wdata[PINS-1:0];
  assign wr_mask = wr_masked ? wdata[2*PINS-1:PINS] : '1;

  for (genvar r = 0; r < NREG; r++) begin : g_reg
    logic [15:0] merged;
    assign merged = merge_masked(16'(regs_q[r]), 16'(wr_mask), 16'(wr_val));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         regs_q[r] <= '0;
      else if (wr_sel[r]) regs_q[r] <= merged[PINS-1:0];
    end
  end

  assign cfg_q = regs_q[0];
  assign oe_q  = regs_q[1];
  assign out_q = regs_q[2];

  // R3: pins outside the mask keep their value
  assert_mask_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[2] && wr_masked) |=>
      ((out_q & ~$past(wdata[2*PINS-1:PINS])) ==
       ($past(out_q) & ~$past(wdata[2*PINS-1:PINS]))));

  // R7: no select, no change
  assert_idle_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == 3'b000) |=> ($stable(cfg_q) && $stable(oe_q) && $stable(out_q)));

  // R2: a plain write loads the low byte whole
  assert_plain_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel[1] && !wr_masked) |=> (oe_q == $past(wdata[PINS-1:0])));

endmodule

// File: rtl/gpio_mask_port.sv
module gpio_mask_port #(
  parameter int NUM_BANKS      = 1,
  parameter int PORTS_PER_BANK = 4,
  parameter int PINS           = 8,
  localparam int BANK_W = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1,
  localparam int ADDR_W = 8 + BANK_W,
  localparam int NPORT  = NUM_BANKS * PORTS_PER_BANK,
  localparam int NPIN   = NPORT * PINS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [NPIN-1:0]   pad_in,
  output logic [NPIN-1:0]   pad_out,
  output logic [NPIN-1:0]   pad_oe
);
  import gpio_mask_pkg::*;

  // Decode of the current address
  logic [BANK_W-1:0] a_bank;
  logic [1:0]        a_port;
  logic [3:0]        a_nib;
  reg_kind_e         a_kind;
  logic              a_alias;
  logic              a_hit;
  int unsigned       a_index;

  assign a_bank  = bus_addr[ADDR_W-1:8];
  assign a_nib   = bus_addr[7:4];
  assign a_port  = bus_addr[3:2];
  assign a_kind  = kind_of(a_nib);
  assign a_alias = is_alias(a_nib);
  assign a_hit   = (a_kind != K_NONE) &&
                   (int'(a_bank) < NUM_BANKS) &&
                   (int'(a_port) < PORTS_PER_BANK);
  assign a_index = int'(a_bank) * PORTS_PER_BANK + int'(a_port);

  // Write event, brought out for the checks
  logic wr_event;
  assign wr_event = bus_we && a_hit && (a_kind != K_IN);

  logic [NPIN-1:0] cfg_vec, oe_vec, out_vec, in_sync;

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    logic [2:0] sel;
    assign sel[0] = wr_event && (a_index == g) && (a_kind == K_CNF);
    assign sel[1] = wr_event && (a_index == g) && (a_kind == K_OE);
    assign sel[2] = wr_event && (a_index == g) && (a_kind == K_OUT);

    gpio_port_regs #(.PINS(PINS)) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_sel   (sel),
      .wr_masked(a_alias),
      .wdata    (bus_wdata),
      .cfg_q    (cfg_vec[g*PINS +: PINS]),
      .oe_q     (oe_vec[g*PINS +: PINS]),
      .out_q    (out_vec[g*PINS +: PINS])
    );
  end

  gpio_in_sync #(.WIDTH(NPIN)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (in_sync)
  );

  assign pad_oe  = cfg_vec & oe_vec;
  assign pad_out = out_vec;

  // Read mux
  always_comb begin
    bus_rdata = '0;
    for (int g = 0; g < NPORT; g++) begin
      if (a_hit && a_index == g) begin
        case (a_kind)
          K_CNF:   bus_rdata[PINS-1:0] = cfg_vec[g*PINS +: PINS];
          K_OE:    bus_rdata[PINS-1:0] = oe_vec[g*PINS +: PINS];
          K_OUT:   bus_rdata[PINS-1:0] = out_vec[g*PINS +: PINS];
          K_IN:    bus_rdata[PINS-1:0] = in_sync[g*PINS +: PINS];
          default: bus_rdata = '0;
        endcase
      end
    end
  end

  // R6: pads move only on write edges
  assert_pads_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_event |=> ($stable(pad_oe) && $stable(pad_out)));

  // R4: upper read bits are zero
  assert_rdata_upper_R4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[31:PINS] == '0);

  // R7: unmapped reads return zero
  assert_unmapped_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !a_hit |-> (bus_rdata == 32'd0));

endmodule

// File: tb/tb_gpio_mask_port.sv
`timescale 1ns/100ps
module tb_gpio_mask_port;
  localparam int NB = 2, NP = 4, PN = 8;
  localparam int AW = 9;
  localparam int NPIN = NB * NP * PN;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic [AW-1:0]   bus_addr = '0;
  logic            bus_we = 1'b0;
  logic [31:0]     bus_wdata = '0;
  logic [31:0]     bus_rdata;
  logic [NPIN-1:0] pad_in = '0;
  logic [NPIN-1:0] pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  gpio_mask_port #(.NUM_BANKS(NB), .PORTS_PER_BANK(NP), .PINS(PN)) dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe));

  typedef struct packed {
    logic        we;
    logic [8:0]  wa;
    logic [31:0] wd;
    logic [8:0]  ra;
    logic [31:0] exp;
  } vec_t;

  // Write (optional), then read back
  localparam vec_t VECS [11] = '{
    '{1'b1, 9'h004, 32'hFFFF_FF5A, 9'h004, 32'h5A},  // R2 upper ignored
    '{1'b1, 9'h098, 32'h0000_0F0F, 9'h018, 32'h0F},  // R3
    '{1'b1, 9'h098, 32'h0000_3C30, 9'h018, 32'h33},  // R3 partial mask
    '{1'b1, 9'h0AC, 32'h0000_00FF, 9'h02C, 32'h00},  // R3 empty mask
    '{1'b1, 9'h02C, 32'h0000_00A5, 9'h0AC, 32'hA5},  // R4 alias read
    '{1'b1, 9'h0AC, 32'h0000_8100, 9'h02C, 32'h24},  // R3 clear two bits
    '{1'b1, 9'h110, 32'h0000_00C3, 9'h110, 32'hC3},  // R9 bank 1
    '{1'b0, 9'h000, 32'h0000_0000, 9'h010, 32'h00},  // R9 bank 0 untouched
    '{1'b1, 9'h040, 32'h0000_00FF, 9'h040, 32'h00},  // R7
    '{1'b1, 9'h0F0, 32'h0000_FFFF, 9'h0F0, 32'h00},  // R7
    '{1'b1, 9'h084, 32'h0000_FF00, 9'h004, 32'h00}   // R3 full mask clear
  };

  function automatic string req_of(input int i);
    case (i)
      0:       req_of = "R2";
      4:       req_of = "R4";
      6, 7:    req_of = "R9";
      8, 9:    req_of = "R7";
      default: req_of = "R3";
    endcase
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd_chk(input string req, input logic [AW-1:0] a, input logic [31:0] exp);
    bus_addr = a;
    #0.5;
    chk(req, 64'(bus_rdata), 64'(exp));
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1", 64'(pad_oe), 64'd0);
    chk("R1", 64'(pad_out), 64'd0);
    rd_chk("R1", 9'h004, 32'h0);
    rd_chk("R1", 9'h12C, 32'h0);

    for (int i = 0; i < 11; i++) begin
      if (VECS[i].we) wr(VECS[i].wa, VECS[i].wd);
      else @(negedge clk);
      rd_chk(req_of(i), VECS[i].ra, VECS[i].exp);
    end

    // R6: drive enable needs configuration and output enable
    wr(9'h008, 32'h0000_00F0);
    chk("R6", 64'(pad_oe), 64'h0000_0000_0030_0000);
    chk("R6", 64'(pad_out), 64'h0000_0000_2400_0000);

    // R5: two-stage synchronizer
    @(negedge clk);
    pad_in = 64'hA500_0000_0000_003C;
    @(negedge clk);
    rd_chk("R5", 9'h030, 32'h00);
    @(negedge clk);
    rd_chk("R5", 9'h030, 32'h3C);
    rd_chk("R5", 9'h13C, 32'hA5);

    // R8: writes to input address have no effect
    wr(9'h030, 32'h0000_00FF);
    rd_chk("R8", 9'h030, 32'h3C);
    chk("R8", 64'(pad_oe), 64'h0000_0000_0030_0000);
    wr(9'h0B0, 32'h0000_FFFF);
    rd_chk("R7", 9'h0B0, 32'h0);
    rd_chk("R8", 9'h030, 32'h3C);
    rd_chk("R8", 9'h02C, 32'h24);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule